// File: doc/BRIEF.md
# Bit Manipulation Instruction Unit

This unit executes the single-bit instructions of a 16-bit processor with eight general registers. It takes one 16-bit instruction word at a time, together with the two values read from the register file. It then sets, clears, inverts or tests one bit of the destination operand. The bit number comes either from a 4-bit immediate in the instruction or from the low bits of a source register. The operand is either the destination register itself or a memory word whose address that register holds.

Register forms finish in one cycle. The result comes back as a register write-back: index, data and a one-cycle enable. A test comes back as a one-cycle result strobe. Memory forms run a read-modify-write on a simple memory port. The unit holds a read request until the data returns, then issues one write cycle of the modified word. A segment-select line marks the segment-prefixed variants. An instruction word that matches none of the six forms raises a one-cycle illegal flag and changes nothing.

Top module: `bit_manip_unit`

## Requirements
- R1: Six forms are recognised: register/register-number (op & 0xF1C8) == 0xE000, register/immediate-number (op & 0xF1C0) == 0xE040, memory/immediate (op & 0xF1C0) == 0xE180, segmented memory/immediate (op & 0xF1C0) == 0xE1C0, memory/register-number (op & 0xF1C8) == 0xE100 and segmented memory/register-number (op & 0xF1C8) == 0xE140. Any other accepted word pulses `illegal` for one cycle with no write-back, no test strobe and no memory request.
- R2: `rd_sel` combinationally equals op[11:9] and `rs_sel` equals op[2:0] of the presented word. Write-backs go to index op[11:9].
- R3: The operation field op[5:4] selects the action: 1 sets, 2 clears and 3 inverts the bit at position n, using mask 1<<n. For register forms, `wb_en` pulses in the cycle after acceptance, with `wb_data` holding the modified `rd_val`.
- R4: In the immediate forms n = op[3:0]. In the register-number forms n = rs_val[3:0], and the upper bits of rs_val have no effect.
- R5: Operation field 0 in the register/immediate form pulses `illegal` and writes nothing back.
- R6: Operation field 0 in the register/register-number form pulses `test_valid` in the cycle after acceptance, with `test_bit` = rd_val[n], and writes nothing back.
- R7: A memory form raises `mem_req` with `mem_we`=0 and `mem_addr`=rd_val in the cycle after acceptance. The read is held with a stable address until `mem_rvalid` is sampled. For operations 1-3 the next cycle is a single write cycle (`mem_req`=1, `mem_we`=1) to the same address, carrying the modified read data; `mem_req` falls after it.
- R8: `mem_seg` is 1 throughout the read and write of the segmented forms (op[6]=1 within the memory group), and 0 for the plain memory forms.
- R9: Operation field 0 in a memory form pulses `test_valid` with `test_bit` = mem_rdata[n] in the cycle after `mem_rvalid`, drops `mem_req` and issues no write.
- R10: `op_ready` is 0 while a memory operation is in progress. An `op_valid` presented then is ignored: no write-back, no illegal flag, no test strobe.
- R11: After reset, `op_ready`=1 and `wb_en`, `test_valid`, `illegal`, `mem_req` and `mem_we` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Instruction word present |
| op | input | 16 | Instruction word |
| op_ready | output | 1 | Unit idle, word accepted this cycle if valid |
| rd_sel | output | 3 | Destination register read index |
| rs_sel | output | 3 | Source register read index |
| rd_val | input | DATA_W | Value of the destination register |
| rs_val | input | DATA_W | Value of the source register |
| wb_en | output | 1 | Register write-back strobe |
| wb_idx | output | 3 | Register write-back index |
| wb_data | output | DATA_W | Register write-back data |
| test_valid | output | 1 | Bit test result strobe |
| test_bit | output | 1 | Tested bit value |
| illegal | output | 1 | Unrecognised or unsupported instruction strobe |
| mem_req | output | 1 | Memory request active |
| mem_we | output | 1 | Memory request is a write |
| mem_seg | output | 1 | Segment-prefixed access |
| mem_addr | output | DATA_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data |
| mem_rvalid | input | 1 | Read data valid |

## Verification
A memory read-modify-write still in flight and a fresh instruction at `op_valid` can fall in the same cycle. The unit must keep the memory sequence intact and let the new word leave no trace. The bench provokes this by presenting a register set instruction in every cycle in which it delays the read data. It judges the outcome by checking that no write-back, illegal flag or test strobe appears and that the memory address and the following write remain those of the original instruction. The expected memory, register and test values come from a bench reference of the mask operation over random operands, bit numbers and latencies.

// File: rtl/bmu_pkg.sv
// Package: shared types and instruction form table for the bit
// manipulation unit. Assumes a 16-bit instruction word with the
// form selected by bits 15:12, 8:6 and (for some forms) bit 3.
package bmu_pkg;

    localparam int unsigned OP_W      = 16;
    localparam int unsigned RIDX_W    = 3;
    localparam int unsigned IMM_W     = 4;
    localparam int unsigned NUM_FORMS = 6;

    typedef enum logic [1:0] {
        BOP_TEST = 2'd0,
        BOP_SET  = 2'd1,
        BOP_CLR  = 2'd2,
        BOP_FLIP = 2'd3
    } bop_e;

    typedef struct packed {
        logic              hit;
        logic              is_mem;
        logic              seg;
        logic              imm;
        bop_e              bop;
        logic [RIDX_W-1:0] rd_idx;
        logic [RIDX_W-1:0] rs_idx;
        logic [IMM_W-1:0]  imm_n;
    } dec_t;

    // Form table: index 0 reg/reg, 1 reg/imm, 2 mem/imm, 3 seg mem/imm,
    // 4 mem/reg, 5 seg mem/reg.
    localparam logic [0:NUM_FORMS-1][OP_W-1:0] FORM_MASK = '{
        16'hF1C8, 16'hF1C0, 16'hF1C0, 16'hF1C0, 16'hF1C8, 16'hF1C8
    };
    localparam logic [0:NUM_FORMS-1][OP_W-1:0] FORM_MATCH = '{
        16'hE000, 16'hE040, 16'hE180, 16'hE1C0, 16'hE100, 16'hE140
    };
    localparam logic [0:NUM_FORMS-1] FORM_IS_MEM = 6'b001111;
    localparam logic [0:NUM_FORMS-1] FORM_IS_SEG = 6'b000101;
    localparam logic [0:NUM_FORMS-1] FORM_IS_IMM = 6'b011100;

endpackage

// File: rtl/bmu_decode.sv
// Module: bmu_decode
// Purely combinational instruction decoder. Compares the word against
// every form of the table in parallel and extracts the register, operation
// and immediate fields. Assumes the forms are mutually exclusive.
module bmu_decode
    import bmu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output dec_t            dec
);

    logic [NUM_FORMS-1:0] form_hit;

    // One comparator per instruction form.
    for (genvar f = 0; f < NUM_FORMS; f++) begin : g_form
        assign form_hit[f] = ((op & FORM_MASK[f]) == FORM_MATCH[f]);
    end

    // Merge the per-form attributes of the matching form and extract the fields.
    always_comb begin
        dec        = '0;
        dec.hit    = |form_hit;
        for (int f = 0; f < NUM_FORMS; f++) begin
            if (form_hit[f]) begin
                dec.is_mem = FORM_IS_MEM[f];
                dec.seg    = FORM_IS_SEG[f];
                dec.imm    = FORM_IS_IMM[f];
            end
        end
        dec.bop    = bop_e'(op[5:4]);
        dec.rd_idx = op[11:9];
        dec.rs_idx = op[2:0];
        dec.imm_n  = op[3:0];
    end

endmodule

// File: rtl/bmu_bitop.sv
// Module: bmu_bitop
// Combinational single-bit operator: builds a one-hot mask from the bit
// number and sets, clears or inverts that bit. It also reports the bit's
// current value. Assumes DATA_W is a power of two no larger than 2**BITN_W.
module bmu_bitop
    import bmu_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    localparam int unsigned BITN_W = $clog2(DATA_W)
) (
    input  bop_e              bop,
    input  logic [DATA_W-1:0] val,
    input  logic [BITN_W-1:0] bitn,
    output logic [DATA_W-1:0] result,
    output logic              bit_tst
);

    logic [DATA_W-1:0] mask;

    // Decoder from bit number to one-hot mask.
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign mask[i] = (bitn == BITN_W'(i));
    end

    // Apply the selected operation to the operand.
    always_comb begin
        unique case (bop)
            BOP_SET:  result = val | mask;
            BOP_CLR:  result = val & ~mask;
            BOP_FLIP: result = val ^ mask;
            default:  result = val;
        endcase
        bit_tst = |(val & mask);
    end

endmodule

// File: rtl/bmu_ctrl.sv
// Module: bmu_ctrl
// Sequencer and output registers. Register forms finish in the cycle
// after acceptance. Memory forms step through read (held until the data is
// valid) and a single write cycle. Assumes the bit operator outside this
// module is fed from the memory data while in_read is high.
module bmu_ctrl
    import bmu_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    localparam int unsigned BITN_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    output logic              op_ready,
    input  logic              d_hit,
    input  logic              d_mem,
    input  logic              d_seg,
    input  logic              d_imm,
    input  bop_e              d_bop,
    input  logic [RIDX_W-1:0] d_rd,
    input  logic [BITN_W-1:0] d_bitn,
    input  logic [DATA_W-1:0] rd_val,
    input  logic [DATA_W-1:0] op_result,
    input  logic              op_bit,
    input  logic              mem_rvalid,
    output logic              in_read,
    output bop_e              held_bop,
    output logic [BITN_W-1:0] held_bitn,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_idx,
    output logic [DATA_W-1:0] wb_data,
    output logic              test_valid,
    output logic              test_bit,
    output logic              illegal,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_seg,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata
);

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } st_e;

    st_e  state_q;
    logic accept;

    assign op_ready = (state_q == ST_IDLE);
    assign accept   = op_valid && op_ready;
    assign in_read  = (state_q == ST_READ);

    // Advance the sequencer and register every result output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            held_bop   <= BOP_TEST;
            held_bitn  <= '0;
            wb_en      <= 1'b0;
            wb_idx     <= '0;
            wb_data    <= '0;
            test_valid <= 1'b0;
            test_bit   <= 1'b0;
            illegal    <= 1'b0;
            mem_req    <= 1'b0;
            mem_we     <= 1'b0;
            mem_seg    <= 1'b0;
            mem_addr   <= '0;
            mem_wdata  <= '0;
        end else begin
            wb_en      <= 1'b0;
            test_valid <= 1'b0;
            illegal    <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    mem_req <= 1'b0;
                    mem_we  <= 1'b0;
                    if (accept) begin
                        if (!d_hit) begin
                            illegal <= 1'b1;
                        end else if (d_mem) begin
                            state_q   <= ST_READ;
                            mem_req   <= 1'b1;
                            mem_seg   <= d_seg;
                            mem_addr  <= rd_val;
                            held_bop  <= d_bop;
                            held_bitn <= d_bitn;
                        end else if (d_bop == BOP_TEST) begin
                            if (d_imm) begin
                                illegal <= 1'b1;
                            end else begin
                                test_valid <= 1'b1;
                                test_bit   <= op_bit;
                            end
                        end else begin
                            wb_en   <= 1'b1;
                            wb_idx  <= d_rd;
                            wb_data <= op_result;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_rvalid) begin
                        if (held_bop == BOP_TEST) begin
                            test_valid <= 1'b1;
                            test_bit   <= op_bit;
                            mem_req    <= 1'b0;
                            state_q    <= ST_IDLE;
                        end else begin
                            mem_we    <= 1'b1;
                            mem_wdata <= op_result;
                            state_q   <= ST_WRITE;
                        end
                    end
                end
                default: begin
                    mem_req <= 1'b0;
                    mem_we  <= 1'b0;
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/bit_manip_unit.sv
// Module: bit_manip_unit
// Top of the bit manipulation unit: decoder, one shared bit operator and
// the sequencer. The bit operator works on the register operand when idle
// and on the returned memory word during a read. Assumes register file
// read data for rd_sel/rs_sel arrives in the same cycle as the index.
module bit_manip_unit
    import bmu_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    localparam int unsigned BITN_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op,
    output logic              op_ready,
    output logic [RIDX_W-1:0] rd_sel,
    output logic [RIDX_W-1:0] rs_sel,
    input  logic [DATA_W-1:0] rd_val,
    input  logic [DATA_W-1:0] rs_val,
    output logic              wb_en,
    output logic [RIDX_W-1:0] wb_idx,
    output logic [DATA_W-1:0] wb_data,
    output logic              test_valid,
    output logic              test_bit,
    output logic              illegal,
    output logic              mem_req,
    output logic              mem_we,
    output logic              mem_seg,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_rvalid
);

    dec_t              dec;
    logic [BITN_W-1:0] cur_bitn;
    logic              in_read;
    bop_e              held_bop;
    logic [BITN_W-1:0] held_bitn;
    bop_e              alu_bop;
    logic [DATA_W-1:0] alu_val;
    logic [BITN_W-1:0] alu_bitn;
    logic [DATA_W-1:0] alu_result;
    logic              alu_bit;
    logic              unused_rs_hi;

    bmu_decode u_decode (
        .op  (op),
        .dec (dec)
    );

    assign rd_sel       = dec.rd_idx;
    assign rs_sel       = dec.rs_idx;
    assign unused_rs_hi = ^rs_val[DATA_W-1:BITN_W];

    // Pick the bit number: the immediate field or the low bits of the source register.
    always_comb begin
        cur_bitn = dec.imm ? BITN_W'(dec.imm_n) : rs_val[BITN_W-1:0];
    end

    // Steer the shared bit operator to the register or the memory operand.
    always_comb begin
        alu_bop  = in_read ? held_bop  : dec.bop;
        alu_val  = in_read ? mem_rdata : rd_val;
        alu_bitn = in_read ? held_bitn : cur_bitn;
    end

    bmu_bitop #(.DATA_W(DATA_W)) u_bitop (
        .bop     (alu_bop),
        .val     (alu_val),
        .bitn    (alu_bitn),
        .result  (alu_result),
        .bit_tst (alu_bit)
    );

    bmu_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_ready   (op_ready),
        .d_hit      (dec.hit),
        .d_mem      (dec.is_mem),
        .d_seg      (dec.seg),
        .d_imm      (dec.imm),
        .d_bop      (dec.bop),
        .d_rd       (dec.rd_idx),
        .d_bitn     (cur_bitn),
        .rd_val     (rd_val),
        .op_result  (alu_result),
        .op_bit     (alu_bit),
        .mem_rvalid (mem_rvalid),
        .in_read    (in_read),
        .held_bop   (held_bop),
        .held_bitn  (held_bitn),
        .wb_en      (wb_en),
        .wb_idx     (wb_idx),
        .wb_data    (wb_data),
        .test_valid (test_valid),
        .test_bit   (test_bit),
        .illegal    (illegal),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .mem_seg    (mem_seg),
        .mem_addr   (mem_addr),
        .mem_wdata  (mem_wdata)
    );

endmodule

// File: rtl/bit_manip_unit_chk.sv
// Module: bit_manip_unit_chk
// Port-level protocol checker for bit_manip_unit, bound into every instance.
// Assumes the synchronous active-low reset of the unit.
module bit_manip_unit_chk #(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              op_valid,
    input logic              op_ready,
    input logic              wb_en,
    input logic              test_valid,
    input logic              illegal,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_seg,
    input logic [DATA_W-1:0] mem_addr,
    input logic              mem_rvalid
);

    // R1/R3/R6: at most one kind of completion per cycle
    a_r1_single_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wb_en, test_valid, illegal, mem_req && mem_we}));

    // R7: a pending read keeps its request and address until data returns
    a_r7_read_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && !mem_rvalid) |=> (mem_req && !mem_we && $stable(mem_addr)));

    // R7/R9: returned read data leads to a write or a test strobe
    a_r7_read_done: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we && mem_rvalid) |=> ((mem_req && mem_we && $stable(mem_addr)) || (test_valid && !mem_req)));

    // R7: the write lasts exactly one cycle
    a_r7_write_once: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |=> !mem_req);

    // R8: segment select does not change inside one memory operation
    a_r8_seg_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> (!mem_req || $stable(mem_seg)));

    // R10: no acceptance while a memory operation is in progress
    a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !op_ready);

    // R10: a word presented while busy produces no register-side outcome
    a_r10_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !op_ready && !mem_we) |=> (!wb_en && !illegal));

endmodule

bind bit_manip_unit bit_manip_unit_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_valid   (op_valid),
    .op_ready   (op_ready),
    .wb_en      (wb_en),
    .test_valid (test_valid),
    .illegal    (illegal),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_seg    (mem_seg),
    .mem_addr   (mem_addr),
    .mem_rvalid (mem_rvalid)
);

// File: tb/bit_manip_unit_bench.sv
// Bench for bit_manip_unit: random and directed instructions, reference
// values from bench functions, counters for checks and failures.
module bit_manip_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [15:0] op = '0;
    logic        op_ready;
    logic [2:0]  rd_sel, rs_sel;
    logic [15:0] rd_val = '0, rs_val = '0;
    logic        wb_en;
    logic [2:0]  wb_idx;
    logic [15:0] wb_data;
    logic        test_valid, test_bit, illegal;
    logic        mem_req, mem_we, mem_seg;
    logic [15:0] mem_addr, mem_wdata;
    logic [15:0] mem_rdata = '0;
    logic        mem_rvalid = 1'b0;

    int checks = 0;
    int fails = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    bit_manip_unit u_bit_manip_unit (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op(op), .op_ready(op_ready),
        .rd_sel(rd_sel), .rs_sel(rs_sel), .rd_val(rd_val), .rs_val(rs_val),
        .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data),
        .test_valid(test_valid), .test_bit(test_bit), .illegal(illegal),
        .mem_req(mem_req), .mem_we(mem_we), .mem_seg(mem_seg),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_rvalid(mem_rvalid)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_apply(input logic [1:0] b, input logic [15:0] v,
                                              input logic [3:0] n);
        logic [15:0] m;
        m = 16'h1 << n;
        case (b)
            2'd1:    return v | m;
            2'd2:    return v & ~m;
            2'd3:    return v ^ m;
            default: return v;
        endcase
    endfunction

    // Form codes: 0 reg/reg, 1 reg/imm, 2 mem/imm, 3 seg mem/imm, 4 mem/reg, 5 seg mem/reg
    function automatic logic [15:0] make_op(input int form, input logic [2:0] rd,
                                            input logic [1:0] b, input logic [3:0] low);
        logic [15:0] base;
        case (form)
            0: base = 16'hE000;
            1: base = 16'hE040;
            2: base = 16'hE180;
            3: base = 16'hE1C0;
            4: base = 16'hE100;
            default: base = 16'hE140;
        endcase
        if (form == 0 || form >= 4) low = {1'b0, low[2:0]};
        return base | {4'h0, rd, 9'h0} | {10'h0, b, 4'h0} | {12'h0, low};
    endfunction

    function automatic bit ref_legal(input logic [15:0] w);
        return ((w & 16'hF1C8) == 16'hE000) || ((w & 16'hF1C0) == 16'hE040) ||
               ((w & 16'hF1C0) == 16'hE180) || ((w & 16'hF1C0) == 16'hE1C0) ||
               ((w & 16'hF1C8) == 16'hE100) || ((w & 16'hF1C8) == 16'hE140);
    endfunction

    // Register forms, R2-R6; also used for illegal words (R1)
    task automatic run_reg(input logic [15:0] w, input logic [15:0] rdv, input logic [15:0] rsv,
                           input int form);
        logic [3:0] n;
        logic [1:0] b;
        @(negedge clk);
        op = w; rd_val = rdv; rs_val = rsv; op_valid = 1'b1;
        #1;
        chk("R2 rd_sel", rd_sel, w[11:9]);
        chk("R2 rs_sel", rs_sel, w[2:0]);
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        b = w[5:4];
        n = (form == 1) ? w[3:0] : rsv[3:0];
        chk("R1 no mem request", mem_req, 0);
        if (form < 0) begin
            chk("R1 illegal flag", illegal, 1);
            chk("R1 no write-back", wb_en, 0);
            chk("R1 no test strobe", test_valid, 0);
        end else if (b == 2'd0 && form == 1) begin
            chk("R5 illegal on immediate test", illegal, 1);
            chk("R5 no write-back", wb_en, 0);
        end else if (b == 2'd0) begin
            chk("R6 test strobe", test_valid, 1);
            chk("R6 test bit (R4 source number)", test_bit, rdv[n]);
            chk("R6 no write-back", wb_en, 0);
        end else begin
            chk("R3 write-back strobe", wb_en, 1);
            chk("R2 write-back index", wb_idx, w[11:9]);
            chk(form == 1 ? "R3 write-back data" : "R4 write-back data", wb_data, ref_apply(b, rdv, n));
            chk("R3 no illegal", illegal, 0);
        end
    endtask

    // Memory forms, R7-R10
    task automatic run_mem(input int form, input logic [2:0] rd, input logic [1:0] b,
                           input logic [3:0] low, input logic [15:0] rdv, input logic [15:0] rsv,
                           input logic [15:0] rdat, input int lat);
        logic [15:0] w;
        logic [3:0]  n;
        logic        seg;
        w = make_op(form, rd, b, low);
        n = (form == 2 || form == 3) ? w[3:0] : rsv[3:0];
        seg = (form == 3 || form == 5);
        @(negedge clk);
        op = w; rd_val = rdv; rs_val = rsv; op_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op_valid = 1'b0;
        chk("R7 read request", {mem_req, mem_we}, 2'b10);
        chk("R7 read address", mem_addr, rdv);
        chk("R8 segment on read", mem_seg, seg);
        chk("R10 busy", op_ready, 0);
        for (int i = 0; i < lat; i++) begin
            op = make_op(1, 3'd2, 2'd1, 4'd5); rd_val = 16'h0000; op_valid = 1'b1;
            @(posedge clk);
            @(negedge clk);
            op_valid = 1'b0;
            chk("R10 busy word ignored", {wb_en, illegal, test_valid}, 3'b000);
            chk("R7 read held", {mem_req, mem_we}, 2'b10);
            chk("R7 read address held", mem_addr, rdv);
        end
        mem_rdata = rdat; mem_rvalid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mem_rvalid = 1'b0;
        mem_rdata = ~rdat;
        if (b == 2'd0) begin
            chk("R9 memory test strobe", test_valid, 1);
            chk("R9 memory test bit", test_bit, rdat[n]);
            chk("R9 no write", mem_req, 0);
        end else begin
            chk("R7 write cycle", {mem_req, mem_we}, 2'b11);
            chk("R7 write address", mem_addr, rdv);
            chk("R7 write data", mem_wdata, ref_apply(b, rdat, n));
            chk("R8 segment on write", mem_seg, seg);
            chk("R10 still busy in write", op_ready, 0);
            @(posedge clk);
            @(negedge clk);
            chk("R7 request ends", mem_req, 0);
        end
        chk("R10 ready again", op_ready, 1);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R11 reset ready", op_ready, 1);
        chk("R11 reset strobes", {wb_en, test_valid, illegal, mem_req, mem_we}, 5'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R11 idle after reset", {wb_en, test_valid, illegal, mem_req, mem_we}, 5'b0);

        // Directed corners
        run_reg(make_op(1, 3'd7, 2'd1, 4'd15), 16'h0000, 16'h0000, 1);  // R3 top bit set
        run_reg(make_op(1, 3'd0, 2'd2, 4'd0), 16'hFFFF, 16'h0000, 1);   // R3 bit 0 clear
        run_reg(make_op(1, 3'd4, 2'd3, 4'd8), 16'h5A5A, 16'h0000, 1);   // R3 invert
        run_reg(make_op(1, 3'd3, 2'd0, 4'd3), 16'hFFFF, 16'h0000, 1);   // R5
        run_reg(make_op(0, 3'd5, 2'd1, 4'd6), 16'h0000, 16'hFFF3, 0);   // R4 upper bits ignored
        run_reg(make_op(0, 3'd1, 2'd0, 4'd2), 16'h8000, 16'h000F, 0);   // R6 test of bit 15
        run_reg(16'hE008, 16'h1234, 16'h0001, -1);                      // R1 neighbour form
        run_reg(16'hE080, 16'h1234, 16'h0001, -1);                      // R1
        run_reg(16'h0000, 16'h1234, 16'h0001, -1);                      // R1
        run_mem(3, 3'd6, 2'd3, 4'd15, 16'hBEEF, 16'h0, 16'h8001, 0);    // R8 segmented, no wait
        run_mem(4, 3'd2, 2'd0, 4'd1, 16'h0100, 16'hFFF0, 16'h0001, 2);  // R9 with R4 number
        run_mem(2, 3'd0, 2'd2, 4'd0, 16'h0002, 16'h0, 16'hFFFF, 3);     // R7 plain clear

        // Random register forms
        for (int i = 0; i < 400; i++) begin
            int f;
            f = int'($urandom_range(1, 0));
            run_reg(make_op(f, 3'($urandom), 2'($urandom), 4'($urandom)),
                    16'($urandom), 16'($urandom), f);
        end
        // Random memory forms
        for (int i = 0; i < 120; i++) begin
            run_mem(int'($urandom_range(5, 2)), 3'($urandom), 2'($urandom), 4'($urandom),
                    16'($urandom), 16'($urandom), 16'($urandom), int'($urandom_range(3, 0)));
        end
        // Random illegal words
        for (int i = 0; i < 200; i++) begin
            logic [15:0] w;
            w = 16'($urandom);
            if (i % 2 == 0) w[15:12] = 4'hE;
            if (!ref_legal(w)) run_reg(w, 16'($urandom), 16'($urandom), -1);
        end

        repeat (2) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule